// File: doc/BRIEF.md
# Seconds-Counting Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of whole seconds plus a sub-second fraction. The fraction advances once for every clock cycle in which the slow-tick input is high, and the seconds count advances when the fraction rolls over. A separate pair of alarm registers is compared against the running {seconds, fraction} value. A match raises a sticky alarm flag. Status flags are cleared by writing ones to them, and a mask register selects which flags drive the single interrupt output.

Register writes are slow on purpose. The bus accepts a write only when no earlier write is still pending. The accepted write takes effect a fixed number of cycles later and then raises a write-complete flag. Any write that arrives while one is pending is thrown away and raises a write-error flag. Software sets the time by writing the fraction to zero and then writing the seconds. The counter stays frozen after reset until the seconds register has been written once, even if the enable bit is already set.

Top module: `sec_rtc`

## Requirements
- R1: After reset every register reads zero, the status register reads 0x202 (non-valid bit 1 and write-ready bit 9 set), and `irq` is low.
- R2: Registers sit at word addresses 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt mask. A write is accepted when no write is pending. It takes effect at the WR_LAT-th rising edge after the accepting edge. Until that edge the target register still reads its old value.
- R3: Status bit 10 (busy) is high exactly while an accepted write is pending. Status bit 9 (write-ready) is its inverse. When the write takes effect, bit 8 (write complete) is set.
- R4: A write presented while busy is dropped, so its target keeps its value, and status bit 7 (write error) is set.
- R5: Status bits 8, 7 and 4 are cleared when a status write with a 1 in that position takes effect. A completing status write sets bit 8 unless its data has bit 8 set.
- R6: Non-valid (bit 1) clears only when a status write with bits 1 and 0 both set takes effect. It never sets again before the next reset. Bit 0 always reads 0.
- R7: Counting is enabled when control bit 3 is set and the seconds register has been written since reset. The fraction is FRAC_W bits held in the top bits of register 1, and the lower bits read zero. The fraction increments once per cycle with `slowTick` high. On wrap it carries into the seconds register, which wraps modulo 2^32.
- R8: The seconds and fraction never change through counting while counting is disabled. This covers control bit 3 clear and the case where seconds have not yet been written.
- R9: Alarm flag bit 4 sets on the edge after a cycle in which counting is enabled and {seconds, fraction} equals {alarm seconds, alarm fraction}. It stays set until cleared. Equality with counting disabled does not set it.
- R10: The mask register keeps only bits 9, 8, 7 and 4 (it reads 0x390 after writing all ones). `irq` is high when any status flag is set and its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register word address for reads and writes |
| wrEn | input | 1 | Write request, sampled on the rising edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the addressed register (combinational) |
| slowTick | input | 1 | Slow time-base strobe; one fraction step per high cycle |
| irq | output | 1 | Interrupt, OR of enabled set status flags |

## Verification
The checker watches several behaviours on every cycle. An accepted write turns busy on, and a taking-effect write turns it off. Writes made while busy raise the error flag. The time value holds still whenever the enable bit is clear and no write lands. The alarm flag and the cleared non-valid flag are sticky. Only the bench scenarios can show the exact write latency, the carry from fraction into seconds and the 32-bit wrap, the freeze before the first seconds write, the edge on which the alarm fires, and the clear semantics of each status bit, because each of these needs an expected value computed across a sequence of writes and ticks.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  // register word addresses
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_FRAC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ASEC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_AFRAC = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd6;

  // status bit positions
  localparam int unsigned B_BUSY  = 10;
  localparam int unsigned B_READY = 9;
  localparam int unsigned B_DONE  = 8;
  localparam int unsigned B_ERR   = 7;
  localparam int unsigned B_ALARM = 4;
  localparam int unsigned B_NVAL  = 1;
  localparam int unsigned B_TAMP  = 0;

  localparam int unsigned B_RUN   = 3;   // control: counter enable

  localparam logic [DATA_W-1:0] MASK_KEEP = 32'h0000_0390;

  // strobes from write control to datapath
  typedef struct packed {
    logic              busy;
    logic              apply;
    logic              dropErr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wrStrb_t;

endpackage

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int unsigned WR_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output wrStrb_t           strb
);

  localparam int unsigned CNT_W = $clog2(WR_LAT + 1);

  logic [CNT_W-1:0]  waitCnt;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic              pending;

  assign pending = (waitCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt  <= '0;
      pendAddr <= '0;
      pendData <= '0;
    end else if (wrEn && !pending) begin
      waitCnt  <= CNT_W'(WR_LAT);
      pendAddr <= addr;
      pendData <= wrData;
    end else if (pending) begin
      waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  always_comb begin
    strb.busy    = pending;
    strb.apply   = (waitCnt == CNT_W'(1));
    strb.dropErr = wrEn && pending;
    strb.addr    = pendAddr;
    strb.data    = pendData;
  end

endmodule

// File: rtl/sec_rtc_dp.sv
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrb_t           strb,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] secsVal,
  output logic              ctrlEn
);

  localparam int unsigned PAD_W = DATA_W - FRAC_W;

  logic [DATA_W-1:0] secs, almSec, almFrac, maskQ, fracReg;
  logic [FRAC_W-1:0] frac;
  logic              runBit, secsSet, doneF, errF, alarmF, nvalF;
  logic              countEn, step, carry, almHit;
  logic              wSec, wFrac, wStat;

  always_comb begin
    wSec    = strb.apply && (strb.addr == A_SEC);
    wFrac   = strb.apply && (strb.addr == A_FRAC);
    wStat   = strb.apply && (strb.addr == A_STAT);
    countEn = runBit && secsSet;
    step    = countEn && slowTick;
    carry   = step && (frac == '1);
    fracReg = {frac, {PAD_W{1'b0}}};
    almHit  = countEn && ({secs, fracReg} == {almSec, almFrac});
  end

  // time value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secs    <= '0;
      frac    <= '0;
      secsSet <= 1'b0;
    end else begin
      if (wSec) begin
        secs    <= strb.data;
        secsSet <= 1'b1;
      end else if (carry) begin
        secs <= secs + DATA_W'(1);
      end
      if (wFrac)     frac <= strb.data[DATA_W-1 -: FRAC_W];
      else if (step) frac <= frac + FRAC_W'(1);
    end
  end

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      almSec  <= '0;
      almFrac <= '0;
      runBit  <= 1'b0;
      maskQ   <= '0;
    end else if (strb.apply) begin
      case (strb.addr)
        A_ASEC:  almSec  <= strb.data;
        A_AFRAC: almFrac <= strb.data;
        A_CTRL:  runBit  <= strb.data[B_RUN];
        A_MASK:  maskQ   <= strb.data & MASK_KEEP;
        default: ;
      endcase
    end
  end

  // sticky status flags, cleared by writing ones
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneF  <= 1'b0;
      errF   <= 1'b0;
      alarmF <= 1'b0;
      nvalF  <= 1'b1;
    end else begin
      doneF  <= (doneF && !(wStat && strb.data[B_DONE]))
              || (strb.apply && !(wStat && strb.data[B_DONE]));
      errF   <= (errF && !(wStat && strb.data[B_ERR])) || strb.dropErr;
      alarmF <= (alarmF && !(wStat && strb.data[B_ALARM])) || almHit;
      nvalF  <= nvalF && !(wStat && strb.data[B_NVAL] && strb.data[B_TAMP]);
    end
  end

  always_comb begin
    stat          = '0;
    stat[B_BUSY]  = strb.busy;
    stat[B_READY] = !strb.busy;
    stat[B_DONE]  = doneF;
    stat[B_ERR]   = errF;
    stat[B_ALARM] = alarmF;
    stat[B_NVAL]  = nvalF;
    irq           = |(stat & maskQ);
    secsVal       = secs;
    ctrlEn        = runBit;
  end

  always_comb begin
    case (addr)
      A_SEC:   rdData = secs;
      A_FRAC:  rdData = fracReg;
      A_ASEC:  rdData = almSec;
      A_AFRAC: rdData = almFrac;
      A_CTRL:  rdData = DATA_W'(runBit) << B_RUN;
      A_STAT:  rdData = stat;
      A_MASK:  rdData = maskQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned WR_LAT = 4,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              slowTick,
  output logic              irq
);

  wrStrb_t           strb;
  logic [DATA_W-1:0] stat;
  logic [DATA_W-1:0] secsVal;
  logic              ctrlEn;

  sec_rtc_ctrl #(.WR_LAT(WR_LAT)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .strb   (strb)
  );

  sec_rtc_dp #(.FRAC_W(FRAC_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .slowTick (slowTick),
    .addr     (addr),
    .rdData   (rdData),
    .irq      (irq),
    .stat     (stat),
    .secsVal  (secsVal),
    .ctrlEn   (ctrlEn)
  );

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              busy,
  input logic              apply,
  input logic [ADDR_W-1:0] applyAddr,
  input logic              applyBit4,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] secsVal,
  input logic              ctrlEn
);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !busy) |=> busy);

  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    apply |=> !stat[B_BUSY]);

  p_drop_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> stat[B_ERR]);

  p_nval_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stat[B_NVAL] |=> !stat[B_NVAL]);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !apply) |=> $stable(secsVal));

  p_alarm_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stat[B_ALARM] && !(apply && applyAddr == A_STAT && applyBit4))
      |=> stat[B_ALARM]);

endmodule

bind sec_rtc sec_rtc_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .busy      (strb.busy),
  .apply     (strb.apply),
  .applyAddr (strb.addr),
  .applyBit4 (strb.data[4]),
  .stat      (stat),
  .secsVal   (secsVal),
  .ctrlEn    (ctrlEn)
);

// File: tb/sim_sec_rtc.sv
module sim_sec_rtc;

  localparam int CLK_PERIOD = 10;
  localparam int WR_LAT     = 4;
  localparam int FRAC_W     = 4;
  localparam int FRAC_SH    = 32 - FRAC_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        slowTick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  sec_rtc #(.WR_LAT(WR_LAT), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .slowTick(slowTick), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  // full write: returns at the negedge after the write has taken effect
  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
    repeat (WR_LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tickOnce();
    @(negedge clk);
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expSec;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reset value", v, (a == 5) ? 32'h202 : 32'h0);
    end
    check("R1 irq low", {31'b0, irq}, 32'h0);

    // R2/R3 write latency and busy window
    @(negedge clk);
    addr = 3'd2; wrData = 32'h0000_1234; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
    for (int i = 0; i < WR_LAT; i++) begin
      @(negedge clk);
      rd(3'd2, v); check("R2 old value while pending", v, 32'h0);
      rd(3'd5, v); check("R3 busy set, ready clear", v & 32'h700, 32'h400);
      @(posedge clk);
    end
    @(negedge clk);
    rd(3'd2, v); check("R2 value after latency", v, 32'h0000_1234);
    rd(3'd5, v); check("R3 done set, ready set", v & 32'h700, 32'h300);

    // R4 write while busy is dropped
    @(negedge clk);
    addr = 3'd3; wrData = 32'hA000_0000; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    addr = 3'd2; wrData = 32'h0000_DEAD;
    @(posedge clk);
    #1 wrEn = 1'b0;
    repeat (WR_LAT) @(posedge clk);
    @(negedge clk);
    rd(3'd2, v); check("R4 dropped write left target", v, 32'h0000_1234);
    rd(3'd3, v); check("R2 first write landed", v, 32'hA000_0000);
    rd(3'd5, v); check("R4 error flag set", v & 32'h80, 32'h80);

    // R5 clear semantics
    busWrite(3'd5, 32'h80);
    rd(3'd5, v); check("R5 error cleared, done set", v & 32'h180, 32'h100);
    busWrite(3'd5, 32'h100);
    rd(3'd5, v); check("R5 done cleared by own write", v & 32'h100, 32'h0);

    // R6 non-valid clear rule
    busWrite(3'd5, 32'h2);
    rd(3'd5, v); check("R6 bit1 alone keeps non-valid", v & 32'h3, 32'h2);
    busWrite(3'd5, 32'h3);
    rd(3'd5, v); check("R6 bits1+0 clear non-valid", v & 32'h3, 32'h0);
    busWrite(3'd5, 32'h100);
    rd(3'd5, v); check("R6 R5 exact status", v, 32'h200);

    // R10 mask
    busWrite(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R10 mask keeps 9,8,7,4", v, 32'h390);
    check("R10 irq from ready flag", {31'b0, irq}, 32'h1);
    busWrite(3'd6, 32'h0);
    check("R10 irq masked off", {31'b0, irq}, 32'h0);

    // R8 frozen before seconds written, enable set
    busWrite(3'd4, 32'h8);
    rd(3'd4, v); check("R2 control readback", v, 32'h8);
    for (int i = 0; i < 20; i++) tickOnce();
    rd(3'd0, v); check("R8 seconds frozen before first write", v, 32'h0);
    rd(3'd1, v); check("R8 fraction frozen before first write", v, 32'h0);

    // R7 counting sweep across fraction wrap and 32-bit seconds wrap
    busWrite(3'd1, 32'h0);
    busWrite(3'd0, 32'hFFFF_FFFE);
    for (int n = 1; n <= 40; n++) begin
      tickOnce();
      expSec = 32'hFFFF_FFFE + 32'(n / (1 << FRAC_W));
      rd(3'd1, v); check("R7 fraction step", v, 32'(n % (1 << FRAC_W)) << FRAC_SH);
      rd(3'd0, v); check("R7 seconds carry", v, expSec);
    end

    // R8 frozen with enable clear
    busWrite(3'd4, 32'h0);
    for (int i = 0; i < 10; i++) tickOnce();
    rd(3'd0, v); check("R8 seconds hold when disabled", v, 32'h0);
    rd(3'd1, v); check("R8 fraction hold when disabled", v, 32'h8 << FRAC_SH);

    // R9 alarm
    busWrite(3'd6, 32'h10);
    busWrite(3'd1, 32'h0);
    busWrite(3'd0, 32'd10);
    busWrite(3'd2, 32'd10);
    busWrite(3'd3, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd5, v); check("R9 no alarm while disabled", v & 32'h10, 32'h0);
    check("R9 R10 irq low while disabled", {31'b0, irq}, 32'h0);
    busWrite(3'd3, 32'h3 << FRAC_SH);
    busWrite(3'd4, 32'h8);
    for (int n = 1; n <= 6; n++) begin
      tickOnce();
      @(negedge clk);
      rd(3'd5, v); check("R9 alarm flag", v & 32'h10, (n >= 3) ? 32'h10 : 32'h0);
      check("R10 alarm irq", {31'b0, irq}, (n >= 3) ? 32'h1 : 32'h0);
    end
    busWrite(3'd5, 32'h10);
    rd(3'd5, v); check("R5 alarm cleared", v & 32'h10, 32'h0);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule